// File: doc/BRIEF.md
# Subvector Element Index Sequencer

This block walks a vector loop of `VL` elements, where each element is a short subvector of one to four lanes. It drives two independent lanes in parallel: a source lane and a destination lane. Each lane has its own subvector length, so a two-wide source can feed a four-wide destination. For every step a lane outputs four values: the element number, the position inside the subvector, the running loop position, and the storage slot that the pair occupies when elements sit next to each other in memory. The lane holds these values until its consumer accepts them with a valid/ready handshake.

A nesting bit, sampled at start, selects the loop order. In normal nesting the element is the outer loop and the subvector position is the inner loop, and the loop position is `elem*LEN+sub`. In pack/unpack nesting the subvector position is the outer loop and the element is the inner loop, and the loop position is `sub*VL+elem`. In both orders the storage slot is `elem*LEN+sub`. In pack/unpack nesting the slot therefore strides across memory while the loop position counts up. All positions and slots are built by adding or incrementing, without a multiplier.

Top module: `elemseq`

## Requirements
- R1: After reset, neither lane asserts valid until a start is accepted.
- R2: With `nest_outer`=1, a lane emits all pairs with the element index changing fastest: sub 0 for elements 0..VL-1, then sub 1, and so on. `pos` = sub*VL+elem.
- R3: With `nest_outer`=0, a lane emits all pairs with the subvector index changing fastest: element 0 for sub 0..LEN-1, then element 1, and so on. `pos` = elem*LEN+sub.
- R4: In both nestings, `slot` equals elem*LEN+sub for every emitted step.
- R5: A lane emits exactly VL*LEN steps, and `pos` rises by one after each accepted step. `last` is high only on the step with elem=VL-1 and sub=LEN-1.
- R6: While a lane's valid is high and its ready is low, every output of that lane holds steady.
- R7: A start with VL=0 produces no valid step on either lane, and the block stays idle and ready for the next start.
- R8: A start that arrives while either lane still has steps pending is ignored. The running walk continues unchanged.
- R9: The 2-bit length codes give LEN = code+1: 0 gives 1, 1 gives 2, 2 gives 3, and 3 gives 4. The source lane uses `src_len_code` and the destination lane uses `dst_len_code`.
- R10: The two lanes are paced independently. Back-pressure on one lane does not stall or reorder the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk when both lanes are idle |
| vl | input | VL_W | Element count for the walk |
| src_len_code | input | 2 | Source subvector length minus one |
| dst_len_code | input | 2 | Destination subvector length minus one |
| nest_outer | input | 1 | 1: subvector index outermost; 0: element outermost |
| src_ready | input | 1 | Source consumer accepts the current step |
| src_valid | output | 1 | Source step available |
| src_last | output | 1 | Final source step |
| src_pos | output | VL_W+2 | Source loop position |
| src_elem | output | VL_W | Source element index |
| src_sub | output | 2 | Source subvector index |
| src_slot | output | VL_W+2 | Source storage slot |
| dst_ready | input | 1 | Destination consumer accepts the current step |
| dst_valid | output | 1 | Destination step available |
| dst_last | output | 1 | Final destination step |
| dst_pos | output | VL_W+2 | Destination loop position |
| dst_elem | output | VL_W | Destination element index |
| dst_sub | output | 2 | Destination subvector index |
| dst_slot | output | VL_W+2 | Destination storage slot |

## Verification
The bench targets the wrap points of each nesting. In pack/unpack order, if the element wrap and the subvector increment happen out of step, a lane will repeat an element or restart the slot stride from the wrong base. In normal order the same fault shows up as a wrong `elem` once the subvector counter rolls over. Other cases covered:
- Length 1 on one lane against length 4 on the other, and a full-width VL. A design that shared one length between the lanes, or let the running sums overflow, would emit the wrong count or the wrong `last`.
- VL of zero, where a faulty design would emit a spurious step or stay busy.
- A second start in the middle of a walk, where a faulty design would restart the walk.
- Long stalls on one lane while the other drains, where any coupling between the lanes would show up as a dropped or duplicated step.

// File: rtl/elemseq_pkg.sv
package elemseq_pkg;
  localparam int SUB_CODE_W = 2;
  localparam int LEN_W      = 3;
  localparam int LANES      = 2;

  typedef enum logic {
    NEST_INNER = 1'b0,
    NEST_OUTER = 1'b1
  } nest_e;

  // length code to subvector length (1..4)
  function automatic logic [LEN_W-1:0] len_of(input logic [SUB_CODE_W-1:0] code);
    return {1'b0, code} + LEN_W'(1);
  endfunction
endpackage

// File: rtl/elemseq_launch.sv
module elemseq_launch
  import elemseq_pkg::*;
#(
  parameter int VL_W = 8
) (
  input  logic                  start,
  input  logic                  busy_any,
  input  logic [SUB_CODE_W-1:0] src_code,
  input  logic [SUB_CODE_W-1:0] dst_code,
  input  logic                  nest_outer,
  output logic                  accept,
  output logic [LEN_W-1:0]      src_len,
  output logic [LEN_W-1:0]      dst_len,
  output nest_e                 nest
);
  // start is taken only when no lane has steps pending
  assign accept  = start && !busy_any;
  assign src_len = len_of(src_code);
  assign dst_len = len_of(dst_code);
  assign nest    = nest_outer ? NEST_OUTER : NEST_INNER;
endmodule

// File: rtl/elemseq_walker.sv
module elemseq_walker
  import elemseq_pkg::*;
#(
  parameter int VL_W  = 8,
  parameter int IDX_W = VL_W + 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [VL_W-1:0]       cfg_vl,
  input  logic [LEN_W-1:0]      cfg_len,
  input  nest_e                 cfg_nest,
  input  logic                  ready,
  output logic                  valid,
  output logic                  last,
  output logic [IDX_W-1:0]      pos,
  output logic [VL_W-1:0]       elem,
  output logic [SUB_CODE_W-1:0] sub,
  output logic [IDX_W-1:0]      slot
);
  typedef struct packed {
    logic [VL_W-1:0]       elem;
    logic [SUB_CODE_W-1:0] sub;
    logic [IDX_W-1:0]      pos;
    logic [IDX_W-1:0]      slot;
  } coord_t;

  // next coordinates; only adders and incrementers
  function automatic coord_t advance(input coord_t c, input nest_e n,
                                     input logic elem_end, input logic sub_end,
                                     input logic [LEN_W-1:0] len);
    coord_t r;
    r     = c;
    r.pos = c.pos + IDX_W'(1);
    if (n == NEST_OUTER) begin
      if (elem_end) begin
        r.elem = '0;
        r.sub  = c.sub + SUB_CODE_W'(1);
        r.slot = IDX_W'(c.sub) + IDX_W'(1);
      end else begin
        r.elem = c.elem + VL_W'(1);
        r.slot = c.slot + IDX_W'(len);
      end
    end else begin
      if (sub_end) begin
        r.sub  = '0;
        r.elem = c.elem + VL_W'(1);
      end else begin
        r.sub  = c.sub + SUB_CODE_W'(1);
      end
      r.slot = c.slot + IDX_W'(1);
    end
    return r;
  endfunction

  logic             busy_q;
  logic [VL_W-1:0]  vl_q;
  logic [LEN_W-1:0] len_q;
  nest_e            nest_q;
  coord_t           cur_q;
  coord_t           nxt;

  // named events
  logic fire;
  logic elem_end;
  logic sub_end;
  logic at_last;

  assign fire     = busy_q && ready;
  assign elem_end = cur_q.elem == (vl_q - VL_W'(1));
  assign sub_end  = ({1'b0, cur_q.sub} + LEN_W'(1)) == len_q;
  assign at_last  = elem_end && sub_end;
  assign nxt      = advance(cur_q, nest_q, elem_end, sub_end, len_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      vl_q   <= '0;
      len_q  <= LEN_W'(1);
      nest_q <= NEST_INNER;
      cur_q  <= '0;
    end else if (load) begin
      busy_q <= cfg_vl != '0;
      vl_q   <= cfg_vl;
      len_q  <= cfg_len;
      nest_q <= cfg_nest;
      cur_q  <= '0;
    end else if (fire) begin
      if (at_last) busy_q <= 1'b0;
      else         cur_q  <= nxt;
    end
  end

  assign valid = busy_q;
  assign last  = busy_q && at_last;
  assign pos   = cur_q.pos;
  assign elem  = cur_q.elem;
  assign sub   = cur_q.sub;
  assign slot  = cur_q.slot;
endmodule

// File: rtl/elemseq.sv
module elemseq
  import elemseq_pkg::*;
#(
  parameter  int VL_W  = 8,
  localparam int IDX_W = VL_W + 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [VL_W-1:0]       vl,
  input  logic [SUB_CODE_W-1:0] src_len_code,
  input  logic [SUB_CODE_W-1:0] dst_len_code,
  input  logic                  nest_outer,
  input  logic                  src_ready,
  output logic                  src_valid,
  output logic                  src_last,
  output logic [IDX_W-1:0]      src_pos,
  output logic [VL_W-1:0]       src_elem,
  output logic [SUB_CODE_W-1:0] src_sub,
  output logic [IDX_W-1:0]      src_slot,
  input  logic                  dst_ready,
  output logic                  dst_valid,
  output logic                  dst_last,
  output logic [IDX_W-1:0]      dst_pos,
  output logic [VL_W-1:0]       dst_elem,
  output logic [SUB_CODE_W-1:0] dst_sub,
  output logic [IDX_W-1:0]      dst_slot
);
  logic                  accept;
  logic                  busy_any;
  nest_e                 nest;
  logic [LEN_W-1:0]      len_a   [LANES];
  logic                  ready_a [LANES];
  logic                  valid_a [LANES];
  logic                  last_a  [LANES];
  logic [IDX_W-1:0]      pos_a   [LANES];
  logic [VL_W-1:0]       elem_a  [LANES];
  logic [SUB_CODE_W-1:0] sub_a   [LANES];
  logic [IDX_W-1:0]      slot_a  [LANES];

  assign busy_any   = valid_a[0] || valid_a[1];
  assign ready_a[0] = src_ready;
  assign ready_a[1] = dst_ready;

  elemseq_launch #(.VL_W(VL_W)) u_launch (
    .start      (start),
    .busy_any   (busy_any),
    .src_code   (src_len_code),
    .dst_code   (dst_len_code),
    .nest_outer (nest_outer),
    .accept     (accept),
    .src_len    (len_a[0]),
    .dst_len    (len_a[1]),
    .nest       (nest)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    elemseq_walker #(.VL_W(VL_W), .IDX_W(IDX_W)) u_walk (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .cfg_vl   (vl),
      .cfg_len  (len_a[g]),
      .cfg_nest (nest),
      .ready    (ready_a[g]),
      .valid    (valid_a[g]),
      .last     (last_a[g]),
      .pos      (pos_a[g]),
      .elem     (elem_a[g]),
      .sub      (sub_a[g]),
      .slot     (slot_a[g])
    );
  end

  assign src_valid = valid_a[0];
  assign src_last  = last_a[0];
  assign src_pos   = pos_a[0];
  assign src_elem  = elem_a[0];
  assign src_sub   = sub_a[0];
  assign src_slot  = slot_a[0];
  assign dst_valid = valid_a[1];
  assign dst_last  = last_a[1];
  assign dst_pos   = pos_a[1];
  assign dst_elem  = elem_a[1];
  assign dst_sub   = sub_a[1];
  assign dst_slot  = slot_a[1];
endmodule

// File: rtl/elemseq_chk.sv
module elemseq_chk #(
  parameter  int VL_W  = 8,
  localparam int IDX_W = VL_W + 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [VL_W-1:0]  vl,
  input logic [1:0]       src_len_code,
  input logic [1:0]       dst_len_code,
  input logic             nest_outer,
  input logic             src_ready,
  input logic             src_valid,
  input logic             src_last,
  input logic [IDX_W-1:0] src_pos,
  input logic [VL_W-1:0]  src_elem,
  input logic [1:0]       src_sub,
  input logic [IDX_W-1:0] src_slot,
  input logic             dst_ready,
  input logic             dst_valid,
  input logic             dst_last,
  input logic [IDX_W-1:0] dst_pos,
  input logic [VL_W-1:0]  dst_elem,
  input logic [1:0]       dst_sub,
  input logic [IDX_W-1:0] dst_slot
);
  logic            taken;
  logic [VL_W-1:0] vl_c;
  logic [2:0]      slen, dlen;
  logic            outer_c;

  assign taken = start && !src_valid && !dst_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vl_c <= '0; slen <= 3'd1; dlen <= 3'd1; outer_c <= 1'b0;
    end else if (taken) begin
      vl_c    <= vl;
      slen    <= {1'b0, src_len_code} + 3'd1;
      dlen    <= {1'b0, dst_len_code} + 3'd1;
      outer_c <= nest_outer;
    end
  end

  a_r2_outer_order: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && src_ready && !src_last && outer_c) |=> src_valid &&
    (($past(src_elem) == vl_c - VL_W'(1)) ?
       (src_elem == '0 && src_sub == $past(src_sub) + 2'd1) :
       (src_elem == $past(src_elem) + VL_W'(1) && src_sub == $past(src_sub))));

  a_r3_inner_order: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && dst_ready && !dst_last && !outer_c) |=> dst_valid &&
    (({1'b0, $past(dst_sub)} + 3'd1 == dlen) ?
       (dst_sub == '0 && dst_elem == $past(dst_elem) + VL_W'(1)) :
       (dst_sub == $past(dst_sub) + 2'd1 && dst_elem == $past(dst_elem))));

  a_r4_src_slot: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid |-> src_slot == IDX_W'(src_elem) * IDX_W'(slen) + IDX_W'(src_sub));

  a_r4_dst_slot: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid |-> dst_slot == IDX_W'(dst_elem) * IDX_W'(dlen) + IDX_W'(dst_sub));

  a_r5_src_last: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid |-> src_last == (src_elem == vl_c - VL_W'(1) && {1'b0, src_sub} + 3'd1 == slen));

  a_r5_pos_step: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && dst_ready && !dst_last) |=> dst_pos == $past(dst_pos) + IDX_W'(1));

  a_r6_src_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && !src_ready) |=> src_valid && $stable(src_pos) && $stable(src_elem) &&
    $stable(src_sub) && $stable(src_slot) && $stable(src_last));

  a_r6_dst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && !dst_ready) |=> dst_valid && $stable(dst_pos) && $stable(dst_slot));

  a_r7_empty_walk: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && vl == '0) |=> !src_valid && !dst_valid);

  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && !src_last && start) |=> src_valid);
endmodule

bind elemseq elemseq_chk #(.VL_W(VL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .vl(vl),
  .src_len_code(src_len_code), .dst_len_code(dst_len_code), .nest_outer(nest_outer),
  .src_ready(src_ready), .src_valid(src_valid), .src_last(src_last), .src_pos(src_pos),
  .src_elem(src_elem), .src_sub(src_sub), .src_slot(src_slot),
  .dst_ready(dst_ready), .dst_valid(dst_valid), .dst_last(dst_last), .dst_pos(dst_pos),
  .dst_elem(dst_elem), .dst_sub(dst_sub), .dst_slot(dst_slot)
);

// File: tb/elemseq_test.sv
`timescale 1ns/1ps
module elemseq_test;
  localparam int VL_W  = 8;
  localparam int IDX_W = VL_W + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [VL_W-1:0] vl = '0;
  logic [1:0] src_len_code = '0, dst_len_code = '0;
  logic nest_outer = 1'b0;
  logic src_ready = 1'b0, dst_ready = 1'b0;
  logic src_valid, src_last, dst_valid, dst_last;
  logic [IDX_W-1:0] src_pos, src_slot, dst_pos, dst_slot;
  logic [VL_W-1:0] src_elem, dst_elem;
  logic [1:0] src_sub, dst_sub;

  always #5 clk = ~clk;

  elemseq #(.VL_W(VL_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl),
    .src_len_code(src_len_code), .dst_len_code(dst_len_code), .nest_outer(nest_outer),
    .src_ready(src_ready), .src_valid(src_valid), .src_last(src_last), .src_pos(src_pos),
    .src_elem(src_elem), .src_sub(src_sub), .src_slot(src_slot),
    .dst_ready(dst_ready), .dst_valid(dst_valid), .dst_last(dst_last), .dst_pos(dst_pos),
    .dst_elem(dst_elem), .dst_sub(dst_sub), .dst_slot(dst_slot)
  );

  typedef struct { int elem; int sub; int pos; int slot; bit outer; } exp_t;
  exp_t qs[$];
  exp_t qd[$];
  int checks = 0, errors = 0;
  bit hs_s = 0, hs_d = 0, done = 0;
  int rdy_mode_s = 0, rdy_mode_d = 0;   // 0 always, 1 random, 2 never

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // independent model: nested loops in the requested order
  task automatic fill(ref exp_t q[$], input int v, input int len, input bit outer);
    exp_t e;
    if (outer) begin
      for (int j = 0; j < len; j++)
        for (int i = 0; i < v; i++) begin
          e.elem = i; e.sub = j; e.pos = j * v + i; e.slot = i * len + j; e.outer = 1;
          q.push_back(e);
        end
    end else begin
      for (int i = 0; i < v; i++)
        for (int j = 0; j < len; j++) begin
          e.elem = i; e.sub = j; e.pos = i * len + j; e.slot = i * len + j; e.outer = 0;
          q.push_back(e);
        end
    end
  endtask

  task automatic check_lane(ref exp_t q[$], input string nm, input bit v, input bit l,
                            input int p, input int e, input int s, input int sl);
    string ord;
    check(v == (q.size() > 0), "R5", {nm, " valid"}, v, q.size() > 0);
    if (v && q.size() > 0) begin
      ord = q[0].outer ? "R2" : "R3";
      check(e == q[0].elem, ord, {nm, " elem"}, e, q[0].elem);
      check(s == q[0].sub,  ord, {nm, " sub"},  s, q[0].sub);
      check(p == q[0].pos,  ord, {nm, " pos"},  p, q[0].pos);
      check(sl == q[0].slot, "R4", {nm, " slot"}, sl, q[0].slot);
      check(l == (q.size() == 1), "R5", {nm, " last"}, l, q.size() == 1);
    end
  endtask

  function automatic bit pick(input int mode);
    if (mode == 0) return 1'b1;
    if (mode == 2) return 1'b0;
    return 1'($urandom_range(0, 1));
  endfunction

  // per-cycle model and comparison, away from the active edge
  always @(negedge clk) begin
    bit busy_b;
    if (!rst_n) begin
      qs.delete(); qd.delete(); hs_s = 0; hs_d = 0;
    end else begin
      busy_b = (qs.size() > 0) || (qd.size() > 0);
      if (hs_s) void'(qs.pop_front());
      if (hs_d) void'(qd.pop_front());
      if (start && !busy_b) begin   // R8: otherwise ignored
        fill(qs, int'(vl), int'(src_len_code) + 1, nest_outer);   // R9
        fill(qd, int'(vl), int'(dst_len_code) + 1, nest_outer);
      end
      check_lane(qs, "src", src_valid, src_last, int'(src_pos), int'(src_elem), int'(src_sub), int'(src_slot));
      check_lane(qd, "dst", dst_valid, dst_last, int'(dst_pos), int'(dst_elem), int'(dst_sub), int'(dst_slot));
      src_ready = pick(rdy_mode_s);
      dst_ready = pick(rdy_mode_d);
      hs_s = (qs.size() > 0) && src_ready;
      hs_d = (qd.size() > 0) && dst_ready;
    end
  end

  task automatic launch(input int v, input int sc, input int dc, input bit outer);
    @(negedge clk); #1;
    start = 1'b1; vl = VL_W'(v); src_len_code = 2'(sc); dst_len_code = 2'(dc); nest_outer = outer;
    @(negedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_idle();
    do begin @(negedge clk); #2; end while (qs.size() > 0 || qd.size() > 0);
    @(negedge clk); #2;
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    // R1: idle after reset
    check(!src_valid && !dst_valid, "R1", "valid after reset", src_valid | dst_valid, 0);

    // R3 normal nesting, lengths 4 and 2 (R9 codes 3 and 1)
    rdy_mode_s = 0; rdy_mode_d = 0;
    launch(5, 3, 1, 0); wait_idle();

    // R2 pack/unpack nesting, lengths 3 and 1, random back-pressure (R6)
    rdy_mode_s = 1; rdy_mode_d = 1;
    launch(3, 2, 0, 1); wait_idle();

    // single element, both lengths 1
    launch(1, 0, 0, 1); wait_idle();
    launch(1, 0, 0, 0); wait_idle();

    // R7: empty walk
    launch(0, 3, 3, 1);
    check(!src_valid && !dst_valid, "R7", "valid on empty walk", src_valid | dst_valid, 0);
    @(negedge clk); #2;
    check(!src_valid && !dst_valid, "R7", "valid after empty walk", src_valid | dst_valid, 0);

    // R8: second start during a walk is ignored
    rdy_mode_s = 1; rdy_mode_d = 0;
    launch(6, 3, 2, 1);
    repeat (3) @(negedge clk);
    launch(2, 0, 0, 0);
    check(src_valid == 1'b1, "R8", "src valid after ignored start", src_valid, 1);
    check(int'(qs.size()) > 0, "R8", "model walk continues", qs.size(), 1);
    wait_idle();

    // R10: destination stalled while source drains
    rdy_mode_s = 0; rdy_mode_d = 2;
    launch(4, 1, 3, 0);
    repeat (12) @(negedge clk);
    #2;
    check(!src_valid, "R10", "src drained during dst stall", src_valid, 0);
    check(dst_valid && dst_pos == '0, "R10", "dst held at first step", int'(dst_pos), 0);
    rdy_mode_d = 1;
    wait_idle();

    // full-width element count, both nestings
    rdy_mode_s = 1; rdy_mode_d = 1;
    launch(255, 3, 2, 1); wait_idle();
    rdy_mode_s = 0; rdy_mode_d = 1;
    launch(255, 0, 3, 0); wait_idle();

    report();
  end
endmodule